// File: doc/BRIEF.md
# PCI Interrupt Pending and Mask Aggregator

This block gathers the error events of a PCI host bridge and the four shared INTx# interrupt lines into one 32-bit interrupt register. Each source has a pending bit in the lower half-word of that register. Each source also has an enable bit exactly 16 positions higher. The block drives one registered interrupt to the system interrupt controller. That interrupt is the OR of every source whose pending bit and enable bit are both set.

Software uses a single register port. A write updates all enable bits at once. Error pending bits are cleared by writing 1 to them. An all-zero word shuts everything down. The INTx pending bits simply mirror the wire levels.

A second, independent query port gives the slot-based INTx swizzle. Given a device number and an interrupt pin (1 to 4), it returns the host line that the pin lands on. Software often splits the error enables into two groups:
- a default group: received master abort, received target abort and signalled target abort;
- an extended group, which adds the two parity classes and signalled system error.

The register treats all enables the same way. The group split is exported as package constants.

Top module: `pci_irq_agg`

## Requirements
- R1: While `rst` is high, and in the first cycle after it, the register reads 0, `irq` is 0 and `q_ok` is 0.
- R2: The register layout is as follows. Every other bit reads 0, and writes to those bits have no effect.
  - Pending bits: bit 0 INTA, bit 1 INTB, bit 2 INTC, bit 3 INTD, bit 4 data parity error, bit 5 signalled target abort, bit 6 received target abort, bit 7 received master abort, bit 8 signalled system error, bit 9 detected parity error.
  - Enable bits: the enable for pending bit n sits at bit n+16.
- R3: `irq` in a cycle equals the OR over bits 9:0 of (enable AND pending), as read in the previous cycle.
- R4: INTx pending bit n reads the inverse of `intx_n[n]` as sampled at the previous clock edge. Register writes never change bits 3:0.
- R5: A pulse on `err_evt[k]` sets pending bit 4+k at the next edge. Index k maps as follows: 0 data parity, 1 signalled target abort, 2 received target abort, 3 received master abort, 4 signalled system error, 5 detected parity.
- R6: A write with bit b set (b in 9..4) clears error pending bit b. A write with bit b clear leaves that bit unchanged, unless the whole word is zero.
- R7: If an event and a clear hit the same error pending bit in the same cycle, the bit ends set.
- R8: Every write loads bits 25:16 of the write data into the enable bits directly.
- R9: A write of the all-zero word clears every enable bit and every error pending bit. An event arriving in the same cycle still sets its bit.
- R10: One cycle after a query, the outputs are as follows.
  - For `q_pin` from 1 to 4: `q_ok`=1 and `q_line` = ((`q_pin`−1) + (`q_slot` AND 3)) AND 3.
  - For any other pin value: `q_ok`=0 and `q_line`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register contents (enables and pending) |
| err_evt | input | 6 | One-cycle error event pulses |
| intx_n | input | 4 | INTA#..INTD# levels, active low |
| q_slot | input | 5 | Device number for the swizzle query |
| q_pin | input | 3 | Interrupt pin of the query, 1=INTA..4=INTD |
| q_line | output | 2 | Host INTx line for the query |
| q_ok | output | 1 | Query pin was in range |
| irq | output | 1 | Combined interrupt, registered |

## Verification
Register state (pending and enable bits) changes at the edge where a write, event or INTx# level is presented, so `reg_rdata` is compared half a cycle after that edge. `irq` sits one more register behind: each vector row predicts `irq` from the register value of the row before, never from its own. Query answers are due one edge after the query is driven and are sampled at the following falling edge. All stimulus is driven on falling edges so that no check races the clock.

// File: rtl/pci_irq_pkg.sv
package pci_irq_pkg;
  localparam int REG_W    = 32;
  localparam int N_INTX   = 4;
  localparam int N_ERR    = 6;
  localparam int N_SRC    = N_INTX + N_ERR;
  localparam int ERR_LSB  = N_INTX;
  localparam int EN_OFS   = 16;
  localparam int LINE_W   = $clog2(N_INTX);

  // error class indices within the error field (bit = ERR_LSB + index)
  localparam int E_DPAR   = 0;
  localparam int E_STABT  = 1;
  localparam int E_RTABT  = 2;
  localparam int E_RMABT  = 3;
  localparam int E_SYSERR = 4;
  localparam int E_DETPAR = 5;

  localparam logic [N_ERR-1:0] ERR_GRP_DEF =
    N_ERR'((1 << E_STABT) | (1 << E_RTABT) | (1 << E_RMABT));
  localparam logic [N_ERR-1:0] ERR_GRP_EXT =
    ERR_GRP_DEF | N_ERR'((1 << E_DPAR) | (1 << E_SYSERR) | (1 << E_DETPAR));

  // enable words a driver would write for each group
  localparam logic [REG_W-1:0] EN_WORD_DEF =
    REG_W'(ERR_GRP_DEF) << (ERR_LSB + EN_OFS);
  localparam logic [REG_W-1:0] EN_WORD_EXT =
    REG_W'(ERR_GRP_EXT) << (ERR_LSB + EN_OFS);
endpackage

// File: rtl/pci_irq_pend.sv
module pci_irq_pend #(
  parameter int N_ERR  = 6,
  parameter int N_INTX = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_ERR-1:0]  evt,
  input  logic [N_ERR-1:0]  clr,
  input  logic              clr_all,
  input  logic [N_INTX-1:0] intx_n,
  output logic [N_ERR-1:0]  err_pend,
  output logic [N_INTX-1:0] intx_pend
);
  for (genvar k = 0; k < N_ERR; k++) begin : g_err
    always_ff @(posedge clk) begin
      if (rst)
        err_pend[k] <= 1'b0;
      else if (evt[k])
        err_pend[k] <= 1'b1;
      else if (clr[k] || clr_all)
        err_pend[k] <= 1'b0;
    end
  end

  for (genvar n = 0; n < N_INTX; n++) begin : g_intx
    always_ff @(posedge clk) begin
      if (rst)
        intx_pend[n] <= 1'b0;
      else
        intx_pend[n] <= ~intx_n[n];
    end
  end
endmodule

// File: rtl/pci_irq_route.sv
module pci_irq_route #(
  parameter int SLOT_W = 5,
  parameter int PIN_W  = 3,
  parameter int N_LINE = 4,
  localparam int LINE_W = $clog2(N_LINE)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [SLOT_W-1:0] slot,
  input  logic [PIN_W-1:0]  pin,
  output logic [LINE_W-1:0] line,
  output logic              ok
);
  logic              pin_ok;
  logic [LINE_W-1:0] pin_idx;
  logic [LINE_W-1:0] sum;
  logic              unused_hi;

  assign pin_ok    = (pin >= PIN_W'(1)) && (pin <= PIN_W'(N_LINE));
  assign pin_idx   = LINE_W'(pin - PIN_W'(1));
  assign sum       = pin_idx + slot[LINE_W-1:0];
  assign unused_hi = ^slot[SLOT_W-1:LINE_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      line <= '0;
      ok   <= 1'b0;
    end else begin
      ok   <= pin_ok;
      line <= pin_ok ? sum : '0;
    end
  end
endmodule

// File: rtl/pci_irq_agg.sv
module pci_irq_agg
  import pci_irq_pkg::*;
#(
  parameter int SLOT_W = 5,
  parameter int PIN_W  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic [5:0]        err_evt,
  input  logic [3:0]        intx_n,
  input  logic [SLOT_W-1:0] q_slot,
  input  logic [PIN_W-1:0]  q_pin,
  output logic [1:0]        q_line,
  output logic              q_ok,
  output logic              irq
);
  logic [N_SRC-1:0]  en_q;
  logic [N_ERR-1:0]  err_pend;
  logic [N_INTX-1:0] intx_pend;
  logic [N_SRC-1:0]  pend;
  logic [N_ERR-1:0]  clr;
  logic              clr_all;
  logic              unused_wbits;

  assign clr     = reg_wr ? reg_wdata[ERR_LSB +: N_ERR] : '0;
  assign clr_all = reg_wr && (reg_wdata == '0);
  assign unused_wbits = ^{reg_wdata[REG_W-1:EN_OFS+N_SRC],
                          reg_wdata[EN_OFS-1:N_SRC],
                          reg_wdata[ERR_LSB-1:0]};

  pci_irq_pend #(.N_ERR(N_ERR), .N_INTX(N_INTX)) u_pend (
    .clk       (clk),
    .rst       (rst),
    .evt       (err_evt),
    .clr       (clr),
    .clr_all   (clr_all),
    .intx_n    (intx_n),
    .err_pend  (err_pend),
    .intx_pend (intx_pend)
  );

  always_ff @(posedge clk) begin
    if (rst)
      en_q <= '0;
    else if (reg_wr)
      en_q <= reg_wdata[EN_OFS +: N_SRC];
  end

  assign pend = {err_pend, intx_pend};

  always_comb begin
    reg_rdata = '0;
    reg_rdata[N_SRC-1:0] = pend;
    reg_rdata[EN_OFS +: N_SRC] = en_q;
  end

  always_ff @(posedge clk) begin
    if (rst)
      irq <= 1'b0;
    else
      irq <= |(pend & en_q);
  end

  pci_irq_route #(.SLOT_W(SLOT_W), .PIN_W(PIN_W), .N_LINE(N_INTX)) u_route (
    .clk  (clk),
    .rst  (rst),
    .slot (q_slot),
    .pin  (q_pin),
    .line (q_line),
    .ok   (q_ok)
  );
endmodule

// File: rtl/pci_irq_agg_chk.sv
module pci_irq_agg_chk #(
  parameter int SLOT_W = 5,
  parameter int PIN_W  = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              reg_wr,
  input logic [31:0]       reg_wdata,
  input logic [31:0]       reg_rdata,
  input logic [5:0]        err_evt,
  input logic [3:0]        intx_n,
  input logic [SLOT_W-1:0] q_slot,
  input logic [PIN_W-1:0]  q_pin,
  input logic [1:0]        q_line,
  input logic              q_ok,
  input logic              irq
);
  // R2: reserved bits never set
  a_r2_reserved_zero: assert property (@(posedge clk) disable iff (rst)
    (reg_rdata[31:26] == '0) && (reg_rdata[15:10] == '0));

  // R3: irq follows the previous register state
  a_r3_irq_follows: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq == $past(|(reg_rdata[25:16] & reg_rdata[9:0]))));

  // R4: INTx pending mirrors inverted inputs one edge later
  a_r4_intx_level: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (reg_rdata[3:0] == ~$past(intx_n)));

  // R5 / R7: an event always leaves its bit set
  a_r5_evt_sets: assert property (@(posedge clk) disable iff (rst)
    (|err_evt) |=> ((reg_rdata[9:4] & $past(err_evt)) == $past(err_evt)));

  // R8: a write loads the enable field
  a_r8_en_load: assert property (@(posedge clk) disable iff (rst)
    reg_wr |=> (reg_rdata[25:16] == $past(reg_wdata[25:16])));

  // R10: query validity
  a_r10_q_ok: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (q_ok == (($past(q_pin) >= 1) && ($past(q_pin) <= 4))));

  // R10: swizzle result
  a_r10_q_line: assert property (@(posedge clk) disable iff (rst)
    q_ok |-> (q_line == 2'(2'(q_pin - 1) + q_slot[1:0])) || !$stable(q_pin)
             || !$stable(q_slot));
endmodule

bind pci_irq_agg pci_irq_agg_chk #(.SLOT_W(SLOT_W), .PIN_W(PIN_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .reg_wr    (reg_wr),
  .reg_wdata (reg_wdata),
  .reg_rdata (reg_rdata),
  .err_evt   (err_evt),
  .intx_n    (intx_n),
  .q_slot    (q_slot),
  .q_pin     (q_pin),
  .q_line    (q_line),
  .q_ok      (q_ok),
  .irq       (irq)
);

// File: tb/test_pci_irq_agg.sv
module test_pci_irq_agg;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [5:0]  err_evt = '0;
  logic [3:0]  intx_n = 4'hF;
  logic [4:0]  q_slot = '0;
  logic [2:0]  q_pin = '0;
  logic [1:0]  q_line;
  logic        q_ok;
  logic        irq;

  int n_cmp = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  pci_irq_agg i_pci_irq_agg (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .err_evt(err_evt), .intx_n(intx_n),
    .q_slot(q_slot), .q_pin(q_pin), .q_line(q_line), .q_ok(q_ok), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // {wr, wdata, evt, intx_n, exp_rdata, exp_irq}
  localparam int NV = 24;
  localparam logic [75:0] VEC [NV] = '{
    {1'b0, 32'h0000_0000, 6'b000000, 4'hF, 32'h0000_0000, 1'b0}, // R1 idle
    {1'b1, 32'h03FF_0000, 6'b000000, 4'hF, 32'h03FF_0000, 1'b0}, // R8
    {1'b0, 32'h0000_0000, 6'b000001, 4'hF, 32'h03FF_0010, 1'b0}, // R5 dpar
    {1'b0, 32'h0000_0000, 6'b000000, 4'hF, 32'h03FF_0010, 1'b1}, // R3
    {1'b1, 32'h03FF_0010, 6'b000000, 4'hF, 32'h03FF_0000, 1'b1}, // R6
    {1'b0, 32'h0000_0000, 6'b000000, 4'hF, 32'h03FF_0000, 1'b0}, // R3
    {1'b0, 32'h0000_0000, 6'b000000, 4'hD, 32'h03FF_0002, 1'b0}, // R4 INTB
    {1'b0, 32'h0000_0000, 6'b000000, 4'hD, 32'h03FF_0002, 1'b1}, // R3
    {1'b1, 32'h03FD_0000, 6'b000000, 4'hD, 32'h03FD_0002, 1'b1}, // R8 mask INTB
    {1'b0, 32'h0000_0000, 6'b000000, 4'hD, 32'h03FD_0002, 1'b0}, // R3 masked
    {1'b1, 32'h03FD_000F, 6'b100000, 4'hF, 32'h03FD_0200, 1'b0}, // R4 R5
    {1'b0, 32'h0000_0000, 6'b000000, 4'hF, 32'h03FD_0200, 1'b1}, // R3
    {1'b1, 32'h03FD_0200, 6'b100000, 4'hF, 32'h03FD_0200, 1'b1}, // R7
    {1'b1, 32'h0000_0000, 6'b000000, 4'hF, 32'h0000_0000, 1'b1}, // R9
    {1'b0, 32'h0000_0000, 6'b000000, 4'hF, 32'h0000_0000, 1'b0}, // R9
    {1'b0, 32'h0000_0000, 6'b001110, 4'hF, 32'h0000_00E0, 1'b0}, // R5 group
    {1'b1, 32'h00E0_0000, 6'b000000, 4'hF, 32'h00E0_00E0, 1'b0}, // R6 keep
    {1'b0, 32'h0000_0000, 6'b000000, 4'hF, 32'h00E0_00E0, 1'b1}, // R3
    {1'b1, 32'h00E0_0080, 6'b000000, 4'hF, 32'h00E0_0060, 1'b1}, // R6
    {1'b1, 32'h0000_0000, 6'b000010, 4'hF, 32'h0000_0020, 1'b1}, // R9 R7
    {1'b0, 32'h0000_0000, 6'b000000, 4'hF, 32'h0000_0020, 1'b0}, // R3
    {1'b1, 32'hFFFF_FFFF, 6'b000000, 4'hF, 32'h03FF_0000, 1'b0}, // R2
    {1'b0, 32'h0000_0000, 6'b000000, 4'hF, 32'h03FF_0000, 1'b0}, // R2
    {1'b1, 32'h0000_0000, 6'b000000, 4'hF, 32'h0000_0000, 1'b0}  // R9
  };

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    chk("R1 rdata in reset", reg_rdata, 32'h0);
    chk("R1 irq in reset", {31'h0, irq}, 32'h0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 rdata after reset", reg_rdata, 32'h0);
    chk("R1 q_ok after reset", {31'h0, q_ok}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      reg_wr    = VEC[i][75];
      reg_wdata = VEC[i][74:43];
      err_evt   = VEC[i][42:37];
      intx_n    = VEC[i][36:33];
      @(negedge clk);
      chk($sformatf("R2-R9 row %0d rdata", i), reg_rdata, VEC[i][32:1]);
      chk($sformatf("R3 row %0d irq", i), {31'h0, irq}, {31'h0, VEC[i][0]});
    end
    reg_wr = 1'b0; err_evt = '0; reg_wdata = '0;

    // R10: swizzle over slots and pins
    for (int s = 0; s < 8; s++) begin
      for (int p = 0; p < 8; p++) begin
        logic [1:0] el;
        logic       eo;
        q_slot = 5'(s * 3);
        q_pin  = 3'(p);
        eo = (p >= 1 && p <= 4);
        el = eo ? 2'((p - 1) + ((s * 3) & 3)) : 2'd0;
        @(negedge clk);
        chk($sformatf("R10 ok slot %0d pin %0d", s * 3, p), {31'h0, q_ok}, {31'h0, eo});
        chk($sformatf("R10 line slot %0d pin %0d", s * 3, p), {30'h0, q_line}, {30'h0, el});
      end
    end

    // R1: mid-run reset with live sources
    reg_wr = 1'b1; reg_wdata = 32'h03FF_0000; intx_n = 4'h0;
    @(negedge clk);
    reg_wr = 1'b0;
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk("R1 rdata under reset", reg_rdata, 32'h0);
    chk("R1 irq under reset", {31'h0, irq}, 32'h0);
    chk("R1 q_ok under reset", {31'h0, q_ok}, 32'h0);
    rst = 1'b0; intx_n = 4'hF;
    @(negedge clk);
    chk("R1 rdata after second reset", reg_rdata, 32'h0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule